// File: doc/BRIEF.md
# Video RAM byte port with address remap

This block lets a byte-wide host write a video memory that holds 16-bit words. The host writes five byte registers: a control register, the low and high halves of a 16-bit word address, and a low-data and a high-data register. Each data write goes straight out as a byte write on the memory port. The byte address is the word address after an optional bit rotation, doubled, with 1 added for the high byte. After the byte that the control register selects, the word address advances by a programmable step.

Each time the host writes an address byte, the block refills a 16-bit read-ahead buffer from the two bytes at the new address. A small fetch machine does this over two cycles on the shared memory port. The machine has three states. IDLE accepts host writes. FETCH_LO drives the even byte address and captures the low buffer byte. FETCH_HI drives the odd byte address and captures the high buffer byte. Its transitions are: IDLE to FETCH_LO on an accepted address-byte write, FETCH_LO to FETCH_HI always, and FETCH_HI to IDLE always. `busy` is high in both fetch states, and host writes that arrive then are discarded.

Memory access is allowed only while the display is blanked or the line counter has reached the end of the visible area. At other times a data write is not issued and a refill loads zeros.

Top module: `vram_port`

## Requirements
- R1: Register selects on `reg_sel` are 0 control, 1 address low byte, 2 address high byte, 3 data low, 4 data high. Control bits 1:0 choose the word-address step: code 0 gives 1, code 1 gives 32, and codes 2 and 3 give 128.
- R2: Control bit 7 chooses which data register advances the address: 0 means the data-low write, 1 means the data-high write. The other data register leaves the address unchanged.
- R3: Control bits 3:2 choose the remap. Mode 0 passes the address through. Mode k (k = 1, 2, 3), with n = 4+k, keeps bits 15 down to n+3, moves bits n-1:0 up by three places, and puts bits n+2:n into bits 2:0.
- R4: `mem_addr` is the remapped word address shifted left by one. A data-low write uses that byte address and a data-high write uses it plus 1. `mem_wdata` carries the written byte in the same cycle that `mem_we` is high.
- R5: An accepted address-byte write puts the block in FETCH_LO for the next cycle and in FETCH_HI for the cycle after that. These cycles read the even and the odd byte of the new address into bits 7:0 and 15:8 of `rd_buf`. `busy` is high exactly in those two cycles.
- R6: While access is closed, a data write does not raise `mem_we`, and a refill cycle loads 0x00 into its byte of `rd_buf`. The address still advances as in R2.
- R7: Access is open when `display_off` is 1, or when `vcount` is at least 225 (`overscan` = 0) or at least 240 (`overscan` = 1).
- R8: The word address wraps from 0xFFFF to 0x0000 when it advances.
- R9: After reset the address, control fields and `rd_buf` are zero, `busy` is low, and the first data-low write goes to byte 0.
- R10: A host write that arrives while `busy` is high has no effect. It issues no memory write and changes neither the address nor the control fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Host register write strobe |
| reg_sel | input | 3 | Register select (R1 encoding) |
| reg_wdata | input | 8 | Host write byte |
| display_off | input | 1 | Display blanked; opens access |
| overscan | input | 1 | Selects the 240-line visible area |
| vcount | input | VCNT_W (9) | Current line number |
| mem_addr | output | 17 | Byte address to the video RAM |
| mem_we | output | 1 | Byte write enable |
| mem_wdata | output | 8 | Byte write data |
| mem_rdata | input | 8 | Read data at `mem_addr`, same cycle |
| busy | output | 1 | Refill in progress |
| rd_buf | output | 16 | Read-ahead buffer |

## Verification
The bench builds the block with its default parameters: a 9-bit line counter and visible heights of 225 and 240. This lets directed cases sit exactly one line either side of both access boundaries, and it covers every remap mode and step code. The external memory is a 4096-byte array indexed by the low address bits, which the reference model aliases the same way. Address writes followed at once by other writes reach the discard path of the fetch machine. A long pseudo-random run mixes control changes, gating changes and overlapping writes.

// File: rtl/vram_port_pkg.sv
package vram_port_pkg;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_FETCH_LO = 2'd1,
        ST_FETCH_HI = 2'd2
    } fetch_state_t;

    localparam logic [2:0] SEL_CTRL    = 3'd0;
    localparam logic [2:0] SEL_ADDR_LO = 3'd1;
    localparam logic [2:0] SEL_ADDR_HI = 3'd2;
    localparam logic [2:0] SEL_DATA_LO = 3'd3;
    localparam logic [2:0] SEL_DATA_HI = 3'd4;

    localparam int WORD_W = 16;
    localparam int BYTE_ADDR_W = WORD_W + 1;

    function automatic logic [7:0] step_of(input logic [1:0] code);
        logic [7:0] s;
        unique case (code)
            2'd0:    s = 8'd1;
            2'd1:    s = 8'd32;
            default: s = 8'd128;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/vram_remap.sv
module vram_remap
    import vram_port_pkg::*;
(
    input  logic [WORD_W-1:0] word_in,
    input  logic [1:0]        mode,
    output logic [WORD_W-1:0] word_out
);

    logic [WORD_W-1:0] cand [4];

    assign cand[0] = word_in;

    for (genvar k = 1; k < 4; k++) begin : g_mode
        localparam int LOW = 4 + k;
        assign cand[k] = {word_in[WORD_W-1:LOW+3],
                          word_in[LOW-1:0],
                          word_in[LOW+2:LOW]};
    end

    assign word_out = cand[mode];

endmodule

// File: rtl/vram_gate.sv
module vram_gate #(
    parameter int VCNT_W = 9,
    parameter int H_NORM = 225,
    parameter int H_OVER = 240
) (
    input  logic              display_off,
    input  logic              overscan,
    input  logic [VCNT_W-1:0] vcount,
    output logic              open
);

    localparam logic [VCNT_W-1:0] LIM_NORM = VCNT_W'(H_NORM);
    localparam logic [VCNT_W-1:0] LIM_OVER = VCNT_W'(H_OVER);

    logic [VCNT_W-1:0] limit;

    assign limit = overscan ? LIM_OVER : LIM_NORM;
    assign open  = display_off || (vcount >= limit);

endmodule

// File: rtl/vram_fetch_fsm.sv
module vram_fetch_fsm
    import vram_port_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic cap_lo,
    output logic cap_hi
);

    fetch_state_t state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_FETCH_LO;
            ST_FETCH_LO: state_nx = ST_FETCH_HI;
            ST_FETCH_HI: state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        busy   = 1'b0;
        cap_lo = 1'b0;
        cap_hi = 1'b0;
        unique case (state)
            ST_IDLE:     ;
            ST_FETCH_LO: begin busy = 1'b1; cap_lo = 1'b1; end
            ST_FETCH_HI: begin busy = 1'b1; cap_hi = 1'b1; end
            default:     ;
        endcase
    end

    // R5
    start_to_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && start) |=> (state == ST_FETCH_LO));
    // R5
    lo_to_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_LO) |=> (state == ST_FETCH_HI));
    // R5
    hi_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FETCH_HI) |=> (state == ST_IDLE));

endmodule

// File: rtl/vram_port.sv
module vram_port
    import vram_port_pkg::*;
#(
    parameter int VCNT_W = 9,
    parameter int H_NORM = 225,
    parameter int H_OVER = 240
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_wr,
    input  logic [2:0]             reg_sel,
    input  logic [7:0]             reg_wdata,
    input  logic                   display_off,
    input  logic                   overscan,
    input  logic [VCNT_W-1:0]      vcount,
    output logic [BYTE_ADDR_W-1:0] mem_addr,
    output logic                   mem_we,
    output logic [7:0]             mem_wdata,
    input  logic [7:0]             mem_rdata,
    output logic                   busy,
    output logic [15:0]            rd_buf
);

    logic [WORD_W-1:0]      word_addr;
    logic [WORD_W-1:0]      mapped;
    logic                   inc_hi;
    logic [1:0]             map_mode;
    logic [1:0]             step_code;
    logic [WORD_W-1:0]      step_val;
    logic                   open;
    logic                   accept, start, cap_lo, cap_hi;
    logic                   is_data_lo, is_data_hi, advance;
    logic [BYTE_ADDR_W-1:0] base_byte;

    vram_remap u_remap (
        .word_in  (word_addr),
        .mode     (map_mode),
        .word_out (mapped)
    );

    vram_gate #(.VCNT_W(VCNT_W), .H_NORM(H_NORM), .H_OVER(H_OVER)) u_gate (
        .display_off (display_off),
        .overscan    (overscan),
        .vcount      (vcount),
        .open        (open)
    );

    vram_fetch_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .busy   (busy),
        .cap_lo (cap_lo),
        .cap_hi (cap_hi)
    );

    assign accept     = reg_wr && !busy;
    assign start      = accept && (reg_sel == SEL_ADDR_LO || reg_sel == SEL_ADDR_HI);
    assign is_data_lo = accept && (reg_sel == SEL_DATA_LO);
    assign is_data_hi = accept && (reg_sel == SEL_DATA_HI);
    assign advance    = (is_data_lo && !inc_hi) || (is_data_hi && inc_hi);
    assign step_val   = {8'd0, step_of(step_code)};
    assign base_byte  = {mapped, 1'b0};

    assign mem_addr  = (cap_hi || is_data_hi) ? (base_byte | BYTE_ADDR_W'(1)) : base_byte;
    assign mem_we    = (is_data_lo || is_data_hi) && open;
    assign mem_wdata = reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_addr <= '0;
            inc_hi    <= 1'b0;
            map_mode  <= 2'd0;
            step_code <= 2'd0;
        end else if (accept) begin
            if (reg_sel == SEL_CTRL) begin
                inc_hi    <= reg_wdata[7];
                map_mode  <= reg_wdata[3:2];
                step_code <= reg_wdata[1:0];
            end else if (reg_sel == SEL_ADDR_LO) begin
                word_addr[7:0] <= reg_wdata;
            end else if (reg_sel == SEL_ADDR_HI) begin
                word_addr[15:8] <= reg_wdata;
            end else if (advance) begin
                word_addr <= word_addr + step_val;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_buf <= '0;
        end else if (cap_lo) begin
            rd_buf[7:0] <= open ? mem_rdata : 8'h00;
        end else if (cap_hi) begin
            rd_buf[15:8] <= open ? mem_rdata : 8'h00;
        end
    end

    // R6
    gate_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !display_off && !overscan) |-> (vcount >= VCNT_W'(H_NORM)));
    // R10
    busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !mem_we);
    // R2
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> (word_addr == $past(word_addr) + $past(step_val)));
    // R6
    refill_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_lo && !open) |=> (rd_buf[7:0] == 8'h00));
    // R10
    busy_addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(word_addr));

endmodule

// File: tb/vram_port_tb_top.sv
`timescale 1ns/100ps
module vram_port_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic        display_off = 1'b1;
    logic        overscan = 1'b0;
    logic [8:0]  vcount = 9'd0;
    logic [16:0] mem_addr;
    logic        mem_we;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        busy;
    logic [15:0] rd_buf;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    string cur_req = "R9";

    logic [7:0] ram [4096];
    logic [7:0] m_ram [4096];
    int m_addr = 0, m_inc_hi = 0, m_mode = 0, m_step = 0, m_phase = 0, m_buf = 0;

    always #2.5 clk = ~clk;

    vram_port dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .display_off(display_off), .overscan(overscan),
        .vcount(vcount), .mem_addr(mem_addr), .mem_we(mem_we),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .busy(busy), .rd_buf(rd_buf)
    );

    assign mem_rdata = ram[mem_addr[11:0]];

    always @(posedge clk) if (mem_we) ram[mem_addr[11:0]] <= mem_wdata;

    function automatic int remap_ref(int a, int m);
        int lw, top;
        if (m == 0) return a;
        lw  = 4 + m;
        top = a & 32'hFFFF & ~((1 << (lw + 3)) - 1);
        return top | ((a & ((1 << lw) - 1)) << 3) | ((a >> lw) & 7);
    endfunction

    function automatic int step_ref(int c);
        if (c == 0) return 1;
        if (c == 1) return 32;
        return 128;
    endfunction

    function automatic bit open_ref();
        int lim;
        lim = overscan ? 240 : 225;
        return display_off || (int'(vcount) >= lim);
    endfunction

    function automatic int byte_ref();
        return remap_ref(m_addr, m_mode) * 2;
    endfunction

    // reference model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_addr = 0; m_inc_hi = 0; m_mode = 0; m_step = 0; m_phase = 0; m_buf = 0;
        end else if (m_phase == 1) begin
            m_buf = (m_buf & 32'hFF00) | (open_ref() ? int'(m_ram[byte_ref() & 4095]) : 0);
            m_phase = 2;
        end else if (m_phase == 2) begin
            m_buf = (m_buf & 32'h00FF) | ((open_ref() ? int'(m_ram[(byte_ref() + 1) & 4095]) : 0) << 8);
            m_phase = 0;
        end else if (reg_wr) begin
            case (reg_sel)
                3'd0: begin
                    m_inc_hi = reg_wdata[7]; m_mode = reg_wdata[3:2]; m_step = reg_wdata[1:0];
                end
                3'd1: begin m_addr = (m_addr & 32'hFF00) | reg_wdata; m_phase = 1; end
                3'd2: begin m_addr = (m_addr & 32'h00FF) | (int'(reg_wdata) << 8); m_phase = 1; end
                3'd3: begin
                    if (open_ref()) m_ram[byte_ref() & 4095] = reg_wdata;
                    if (m_inc_hi == 0) m_addr = (m_addr + step_ref(m_step)) & 32'hFFFF;
                end
                3'd4: begin
                    if (open_ref()) m_ram[(byte_ref() + 1) & 4095] = reg_wdata;
                    if (m_inc_hi == 1) m_addr = (m_addr + step_ref(m_step)) & 32'hFFFF;
                end
                default: ;
            endcase
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the rising edge
    always begin
        @(negedge clk);
        #1.5;
        if (rst_n && !done) begin
            bit exp_we;
            int exp_a;
            exp_we = reg_wr && m_phase == 0 && (reg_sel == 3'd3 || reg_sel == 3'd4) && open_ref();
            chk(busy == (m_phase != 0), {cur_req, " busy"}, busy, m_phase != 0);
            chk(int'(rd_buf) == m_buf, {cur_req, " rd_buf"}, rd_buf, m_buf);
            chk(mem_we == exp_we, {cur_req, " mem_we"}, mem_we, exp_we);
            if (exp_we) begin
                exp_a = (byte_ref() + (reg_sel == 3'd4 ? 1 : 0)) & 32'h1FFFF;
                chk(int'(mem_addr) == exp_a, {cur_req, " mem_addr"}, mem_addr, exp_a);
                chk(mem_wdata == reg_wdata, {cur_req, " mem_wdata"}, mem_wdata, reg_wdata);
            end else if (m_phase != 0) begin
                exp_a = (byte_ref() + (m_phase == 2 ? 1 : 0)) & 32'h1FFFF;
                chk(int'(mem_addr) == exp_a, {cur_req, " fetch addr"}, mem_addr, exp_a);
            end
        end
    end

    task automatic op(logic [2:0] s, logic [7:0] d);
        @(negedge clk); #0.5;
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #0.5;
            reg_wr = 1'b0;
        end
    endtask

    task automatic set_addr(int a);
        op(3'd1, a[7:0]); idle(3);
        op(3'd2, a[15:8]); idle(3);
    endtask

    task automatic pair(logic [7:0] lo, logic [7:0] hi);
        op(3'd3, lo); op(3'd4, hi); idle(1);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) begin ram[i] = 8'h00; m_ram[i] = 8'h00; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        // R9: reset values, then first write at byte 0
        chk(rd_buf == 16'h0, "R9 reset rd_buf", rd_buf, 0);
        chk(busy == 1'b0, "R9 reset busy", busy, 0);
        @(negedge clk); #0.5; reg_wr = 1'b1; reg_sel = 3'd3; reg_wdata = 8'hA5;
        #1.0;
        chk(mem_addr == 17'h0 && mem_we, "R9 first write addr", mem_addr, 0);
        idle(1);

        // R1 R2 R4: step codes and trigger byte
        cur_req = "R1";
        for (int c = 0; c < 4; c++) begin
            op(3'd0, 8'(c)); idle(1);
            set_addr(16'h0040 + c);
            pair(8'h10 + 8'(c), 8'h20 + 8'(c));
            pair(8'h30, 8'h31);
        end
        cur_req = "R2";
        op(3'd0, 8'h81); idle(1);
        set_addr(16'h0100);
        pair(8'h44, 8'h55); pair(8'h66, 8'h77);
        cur_req = "R4";
        set_addr(16'h0100); set_addr(16'h0120);

        // R3: each remap mode, write then read back through refill
        cur_req = "R3";
        for (int m = 0; m < 4; m++) begin
            op(3'd0, 8'((m << 2))); idle(1);
            set_addr(16'h12E7 + 16'(m * 16'h0111));
            pair(8'hC0 + 8'(m), 8'hD0 + 8'(m));
            set_addr(16'h12E7 + 16'(m * 16'h0111));
        end

        // R6 R7: gating boundaries
        cur_req = "R7";
        op(3'd0, 8'h00); idle(1);
        display_off = 1'b0;
        foreach (vcount[i]) ;
        for (int k = 0; k < 4; k++) begin
            overscan = k[1];
            vcount   = (k[1] ? 9'd240 : 9'd225) - (k[0] ? 9'd0 : 9'd1);
            cur_req  = k[0] ? "R7" : "R6";
            set_addr(16'h0200 + 16'(k * 4));
            pair(8'h5A + 8'(k), 8'hA5 - 8'(k));
            set_addr(16'h0200 + 16'(k * 4));
        end
        overscan = 1'b0; vcount = 9'd10;
        cur_req = "R6";
        set_addr(16'h0040);
        display_off = 1'b1;

        // R8: wrap of the word address
        cur_req = "R8";
        op(3'd0, 8'h00); idle(1);
        set_addr(16'hFFFF);
        pair(8'hE1, 8'hE2); pair(8'hE3, 8'hE4);
        op(3'd0, 8'h02); idle(1);
        set_addr(16'hFF90);
        pair(8'h01, 8'h02); pair(8'h03, 8'h04);

        // R10: writes during refill are discarded
        cur_req = "R10";
        op(3'd1, 8'h08); op(3'd3, 8'h99); op(3'd0, 8'h8F); idle(3);
        op(3'd2, 8'h03); op(3'd2, 8'h77); op(3'd4, 8'h11); idle(3);
        pair(8'h21, 8'h22);

        // mixed pseudo-random traffic
        cur_req = "R5";
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 16;
            if (r < 2)       op(3'd0, 8'($urandom));
            else if (r < 4)  op(3'($urandom % 2 + 1), 8'($urandom));
            else if (r < 10) op(3'($urandom % 2 + 3), 8'($urandom));
            else if (r < 12) begin
                display_off = ($urandom % 3) == 0;
                overscan    = $urandom % 2;
                vcount      = 9'(215 + $urandom % 35);
                idle(1);
            end else idle(1);
        end
        idle(4);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule